// File: doc/BRIEF.md
# Chroma-Key Merge Unit

This block composites a foreground image over a background image, working on one 64-bit beat at a time. A beat holds eight 8-bit pixels. Every foreground pixel that equals a programmable key colour is replaced by the background pixel in the same lane. All other foreground pixels pass through unchanged.

The block never picks a pixel through a per-lane branch. It first compares each foreground byte with the key and builds a byte mask. The mask is ANDed with the background word, and its inverse is ANDed with the foreground word. The two partial words are then ORed to form the composite.

The foreground and background arrive on two separate valid/ready streams, and the composite leaves on a third. The key is a single byte that the block repeats across all eight lanes. The result is registered, so a beat accepted on one clock edge shows at the output after that edge. With both inputs valid and the output ready, the block takes one beat on every cycle.

Top module: `chroma_key_merge`

## Requirements
- R1: After reset, `out_valid` is 0, `out_data` and `out_mask` are all zeros, and the key colour equals the parameter `KEY_RST` (default 8'h00).
- R2: For each lane i, where lane i is bits [8i+7:8i], the output lane equals the background lane when the foreground lane equals the key, and equals the foreground lane otherwise.
- R3: Lane i of `out_mask` is 8'hFF when foreground lane i matched the key, and 8'h00 when it did not.
- R4: A beat is accepted only when both inputs are valid and the output register is empty or is being read in the same cycle. Under those conditions `fg_ready` and `bg_ready` are both 1, so one stream is never consumed without the other.
- R5: While `out_valid` is 1 and `out_ready` is 0, `out_data` and `out_mask` hold their values and no new beat is accepted.
- R6: A key write (`key_wr`=1) that happens in the same cycle as an accepted beat does not affect that beat. The new key applies from the next accepted beat onward.
- R7: An accepted beat appears on the output after the accepting clock edge. If the inputs and the output stay ready on every cycle, the block accepts one beat per cycle and produces one result per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_wr | input | 1 | Load the key colour from `key_val` |
| key_val | input | 8 | New key colour |
| fg_valid | input | 1 | Foreground beat is valid |
| fg_ready | output | 1 | Foreground beat is taken |
| fg_data | input | 64 | Eight foreground pixels |
| bg_valid | input | 1 | Background beat is valid |
| bg_ready | output | 1 | Background beat is taken |
| bg_data | input | 64 | Eight background pixels |
| out_valid | output | 1 | Composite beat is valid |
| out_ready | input | 1 | Downstream takes the composite |
| out_data | output | 64 | Composite pixels |
| out_mask | output | 64 | Per-lane match mask |

## Verification
The compositing path is driven with several foreground words:
- every lane equal to the key,
- no lane equal to the key,
- matching lanes alternating with non-matching lanes,
- a match only in lane 0 or only in lane 7.

These patterns catch a mask that is inverted, a lane that is shifted, and a mask bit that is dropped at either end of the word. A pixel that differs from the key by a single bit is also sent, to show that only exact equality counts as a match.

The handshake tests cover three cases: only one input stream valid, a stalled output, and a long back-to-back stream. Together they separate correct pairing of the two inputs from holding the output and from full per-cycle throughput. A key write in the same cycle as a beat tells the old key from the new one.

// File: rtl/ckm_pkg.sv
package ckm_pkg;
  localparam int CKM_PIX_W = 8;
  localparam int CKM_LANES = 8;
endpackage

// File: rtl/ckm_key_reg.sv
module ckm_key_reg #(
  parameter int PIX_W = ckm_pkg::CKM_PIX_W,
  parameter int LANES = ckm_pkg::CKM_LANES,
  parameter logic [PIX_W-1:0] KEY_RST = '0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr,
  input  logic [PIX_W-1:0]       val,
  output logic [PIX_W*LANES-1:0] key_rep
);
  logic [PIX_W-1:0] key_q;

  // new key becomes visible the cycle after the write (R6)
  always_ff @(posedge clk) begin
    if (rst)     key_q <= KEY_RST;
    else if (wr) key_q <= val;
  end

  assign key_rep = {LANES{key_q}};
endmodule

// File: rtl/ckm_mask_gen.sv
module ckm_mask_gen #(
  parameter int PIX_W = ckm_pkg::CKM_PIX_W,
  parameter int LANES = ckm_pkg::CKM_LANES,
  localparam int WORD_W = PIX_W * LANES
) (
  input  logic [WORD_W-1:0] fg,
  input  logic [WORD_W-1:0] key_rep,
  output logic [WORD_W-1:0] mask
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    assign mask[l*PIX_W +: PIX_W] =
      (fg[l*PIX_W +: PIX_W] == key_rep[l*PIX_W +: PIX_W]) ? {PIX_W{1'b1}} : {PIX_W{1'b0}};
  end
endmodule

// File: rtl/ckm_blend.sv
module ckm_blend #(
  parameter int WORD_W = ckm_pkg::CKM_PIX_W * ckm_pkg::CKM_LANES
) (
  input  logic [WORD_W-1:0] fg,
  input  logic [WORD_W-1:0] bg,
  input  logic [WORD_W-1:0] mask,
  output logic [WORD_W-1:0] res
);
  logic [WORD_W-1:0] keep_bg, keep_fg;

  assign keep_bg = bg & mask;
  assign keep_fg = fg & ~mask;
  assign res     = keep_bg | keep_fg;
endmodule

// File: rtl/chroma_key_merge.sv
module chroma_key_merge #(
  parameter int PIX_W = ckm_pkg::CKM_PIX_W,
  parameter int LANES = ckm_pkg::CKM_LANES,
  parameter logic [PIX_W-1:0] KEY_RST = '0,
  localparam int WORD_W = PIX_W * LANES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_wr,
  input  logic [PIX_W-1:0]  key_val,
  input  logic              fg_valid,
  output logic              fg_ready,
  input  logic [WORD_W-1:0] fg_data,
  input  logic              bg_valid,
  output logic              bg_ready,
  input  logic [WORD_W-1:0] bg_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [WORD_W-1:0] out_data,
  output logic [WORD_W-1:0] out_mask
);
  logic [WORD_W-1:0] key_rep, mask_c, res_c;
  logic space, fire;

  ckm_key_reg #(.PIX_W(PIX_W), .LANES(LANES), .KEY_RST(KEY_RST)) u_key (
    .clk(clk), .rst(rst), .wr(key_wr), .val(key_val), .key_rep(key_rep)
  );

  ckm_mask_gen #(.PIX_W(PIX_W), .LANES(LANES)) u_mask (
    .fg(fg_data), .key_rep(key_rep), .mask(mask_c)
  );

  ckm_blend #(.WORD_W(WORD_W)) u_blend (
    .fg(fg_data), .bg(bg_data), .mask(mask_c), .res(res_c)
  );

  assign space    = !out_valid || out_ready;
  assign fg_ready = space && bg_valid;
  assign bg_ready = space && fg_valid;
  assign fire     = space && fg_valid && bg_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
      out_mask  <= '0;
    end else if (fire) begin
      out_valid <= 1'b1;
      out_data  <= res_c;
      out_mask  <= mask_c;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R5: stalled output holds
  p_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_mask)));

  // R4: both streams are consumed together
  p_pair_r4: assert property (@(posedge clk) disable iff (rst)
    (fg_valid && fg_ready) == (bg_valid && bg_ready));

  // R4: no acceptance while the output is stalled
  p_stall_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> (!fg_ready && !bg_ready));

  // R7: accepted beat shows up after the edge
  p_fill_r7: assert property (@(posedge clk) disable iff (rst)
    (fg_valid && fg_ready) |=> out_valid);

  // R3: each mask lane is all ones or all zeros
  for (genvar l = 0; l < LANES; l++) begin : g_mchk
    p_mask_r3: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> (out_mask[l*PIX_W +: PIX_W] == {PIX_W{1'b0}} ||
                     out_mask[l*PIX_W +: PIX_W] == {PIX_W{1'b1}}));
  end
endmodule

// File: tb/chroma_key_merge_tb.sv
module chroma_key_merge_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PW = 8;
  localparam int NL = 8;
  localparam int WW = PW * NL;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic key_wr = 1'b0;
  logic [PW-1:0] key_val = '0;
  logic fg_valid = 1'b0, bg_valid = 1'b0, out_ready = 1'b1;
  logic fg_ready, bg_ready, out_valid;
  logic [WW-1:0] fg_data = '0, bg_data = '0, out_data, out_mask;
  int total = 0, bad = 0;
  logic [PW-1:0] cur_key = 8'h00;

  always #(CLK_PERIOD/2) clk = ~clk;

  chroma_key_merge u_dut (
    .clk(clk), .rst(rst), .key_wr(key_wr), .key_val(key_val),
    .fg_valid(fg_valid), .fg_ready(fg_ready), .fg_data(fg_data),
    .bg_valid(bg_valid), .bg_ready(bg_ready), .bg_data(bg_data),
    .out_valid(out_valid), .out_ready(out_ready),
    .out_data(out_data), .out_mask(out_mask)
  );

  function automatic logic [WW-1:0] ref_res(input logic [WW-1:0] f, input logic [WW-1:0] b,
                                            input logic [PW-1:0] k);
    logic [WW-1:0] r;
    for (int l = 0; l < NL; l++)
      r[l*PW +: PW] = (f[l*PW +: PW] == k) ? b[l*PW +: PW] : f[l*PW +: PW];
    return r;
  endfunction

  function automatic logic [WW-1:0] ref_mask(input logic [WW-1:0] f, input logic [PW-1:0] k);
    logic [WW-1:0] m;
    for (int l = 0; l < NL; l++)
      m[l*PW +: PW] = (f[l*PW +: PW] == k) ? 8'hFF : 8'h00;
    return m;
  endfunction

  task automatic chk(input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // one beat with open output; checks result and mask (R2, R3)
  task automatic beat(input logic [WW-1:0] f, input logic [WW-1:0] b);
    @(negedge clk);
    fg_data = f; bg_data = b; fg_valid = 1'b1; bg_valid = 1'b1; out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fg_valid = 1'b0; bg_valid = 1'b0;
    chk("R7 valid", {63'd0, out_valid}, 64'd1);
    chk("R2 data", out_data, ref_res(f, b, cur_key));
    chk("R3 mask", out_mask, ref_mask(f, cur_key));
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk("R1 valid", {63'd0, out_valid}, 64'd0);
    chk("R1 data", out_data, '0);
    chk("R1 mask", out_mask, '0);
    cur_key = 8'h00;
    // reset key 00: lane 2 is zero and must be replaced
    beat(64'h1111_1111_1100_1111, 64'hAAAA_AAAA_AAAA_AAAA);
  endtask

  task automatic t_key_set(input logic [PW-1:0] k);
    @(negedge clk);
    key_wr = 1'b1; key_val = k;
    @(negedge clk);
    key_wr = 1'b0;
    cur_key = k;
  endtask

  task automatic t_patterns;
    t_key_set(8'h3C);
    beat({8{8'h3C}}, 64'h0102_0304_0506_0708);         // all lanes match (R2)
    beat(64'h0011_2233_4455_6677, 64'hFFEE_DDCC_BBAA_9988); // none (R2)
    beat(64'h3C55_3C55_3C55_3C55, 64'h1234_5678_9ABC_DEF0); // alternate (R3)
    beat(64'h0000_0000_0000_003C, 64'hC0C1_C2C3_C4C5_C6C7); // lane 0 only (R3)
    beat(64'h3C00_0000_0000_0000, 64'hC0C1_C2C3_C4C5_C6C7); // lane 7 only (R3)
    beat(64'h3D3C_BC1C_3E3C_7C3C, 64'hA0A1_A2A3_A4A5_A6A7); // near misses (R2)
  endtask

  task automatic t_one_side;
    @(negedge clk);
    out_ready = 1'b1; fg_valid = 1'b1; bg_valid = 1'b0;
    fg_data = 64'h5555_5555_5555_5555;
    #1 chk("R4 fg_ready one side", {63'd0, fg_ready}, 64'd0);
    chk("R4 bg_ready one side", {63'd0, bg_ready}, 64'd1);
    @(posedge clk);
    @(negedge clk);
    chk("R4 no beat on one side", {63'd0, out_valid}, 64'd0);
    fg_valid = 1'b0; bg_valid = 1'b1;
    #1 chk("R4 bg_ready other side", {63'd0, bg_ready}, 64'd0);
    @(posedge clk);
    @(negedge clk);
    bg_valid = 1'b0;
    chk("R4 no beat other side", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_stall;
    logic [WW-1:0] fa = 64'h3C3C_0000_3C3C_0000, ba = 64'h1111_2222_3333_4444;
    logic [WW-1:0] fb = 64'h0000_3C3C_0000_3C3C, bb = 64'h9999_8888_7777_6666;
    @(negedge clk);
    out_ready = 1'b0; fg_data = fa; bg_data = ba; fg_valid = 1'b1; bg_valid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fg_data = fb; bg_data = bb;
    #1 chk("R4 ready low in stall", {62'd0, fg_ready, bg_ready}, 64'd0);
    for (int i = 0; i < 3; i++) begin
      @(posedge clk);
      @(negedge clk);
      chk("R5 hold data", out_data, ref_res(fa, ba, cur_key));
      chk("R5 hold mask", out_mask, ref_mask(fa, cur_key));
    end
    out_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    fg_valid = 1'b0; bg_valid = 1'b0;
    chk("R5 next after release", out_data, ref_res(fb, bb, cur_key));
    @(posedge clk);
    @(negedge clk);
    chk("R7 drains", {63'd0, out_valid}, 64'd0);
  endtask

  task automatic t_key_race;
    logic [WW-1:0] f = 64'h3C3C_5A5A_3C3C_5A5A, b = 64'hEEEE_EEEE_EEEE_EEEE;
    @(negedge clk);
    fg_data = f; bg_data = b; fg_valid = 1'b1; bg_valid = 1'b1; out_ready = 1'b1;
    key_wr = 1'b1; key_val = 8'h5A;
    @(posedge clk);
    @(negedge clk);
    key_wr = 1'b0;
    chk("R6 old key on same beat", out_data, ref_res(f, b, 8'h3C));
    @(posedge clk);
    @(negedge clk);
    fg_valid = 1'b0; bg_valid = 1'b0;
    cur_key = 8'h5A;
    chk("R6 new key next beat", out_data, ref_res(f, b, 8'h5A));
  endtask

  task automatic t_stream;
    logic [WW-1:0] f, b;
    @(negedge clk);
    out_ready = 1'b1; fg_valid = 1'b1; bg_valid = 1'b1;
    for (int i = 0; i < 6; i++) begin
      f = {8{8'(i * 17)}} ^ 64'h5A00_5A00_005A_005A;
      b = {8{8'(8'hC0 + i)}};
      fg_data = f; bg_data = b;
      #1 chk("R7 ready each cycle", {62'd0, fg_ready, bg_ready}, 64'd3);
      @(posedge clk);
      @(negedge clk);
      chk("R7 stream data", out_data, ref_res(f, b, cur_key));
    end
    fg_valid = 1'b0; bg_valid = 1'b0;
  endtask

  initial begin
    fork
      begin
        t_reset();
        t_patterns();
        t_one_side();
        t_stall();
        t_key_race();
        t_stream();
      end
      begin
        repeat (20000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=done");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule